// File: doc/BRIEF.md
# Busy-Triggered Serial Converter Reader

This block is the clock-generating side of a three-wire read link to an external converter that has no clock of its own. It watches the converter's busy output. When a conversion finishes, it sends a single burst of exactly sixteen serial clock pulses. Between bursts the clock stays low. On the falling edge of each pulse it captures the converter's data line, most significant bit first. After the last bit it presents the 16-bit word on a parallel output, together with a valid strobe one system clock wide.

Several converters can share the one burst generator. Each has its own output clock line, which is the master clock ANDed with that device's active-high select bit, so a device whose select is low sees no clock edges. The `auto_start` input picks how a read begins. With it high, the end-of-conversion edge of busy starts the read directly. With it low, that edge only raises `irq_flag`, and the host then starts the read with `read_req`.

The controller is one state machine with five states. IDLE holds the clock low and waits for a start. LEAD holds the clock low for one half-period. HIGH drives the clock high for one half-period and samples data as it leaves. LOW drives the clock low for one half-period between pulses. DONE lasts one cycle and raises the valid strobe. The transitions are:
- start: IDLE to LEAD.
- lead_done: LEAD to HIGH.
- fall_sample: HIGH to LOW.
- rise: LOW to HIGH.
- last_sample: HIGH to DONE, after the sixteenth sample.
- finish: DONE to IDLE.

Top module: `adc_burst_reader`

## Requirements
- R1: A synchronous active-high `rst` returns the block to IDLE. While in reset and on the first cycle after it, every `sclk_out` bit is 0, `data_valid` is 0 and `irq_flag` is 0.
- R2: Each read produces exactly 16 rising edges on the clock line of every selected device.
- R3: After a start, the clock stays low for DIV_HALF system cycles before its first rising edge. Each high phase lasts exactly DIV_HALF cycles. The clock is low whenever no read is running.
- R4: The data line is sampled when the clock falls. The first bit sampled lands in `data_out[15]` and the last in `data_out[0]`, with no reversal.
- R5: `data_valid` is high for exactly one cycle, right after the sixteenth sample. `data_out` keeps the word after the strobe.
- R6: `sclk_out[i]` equals the master clock ANDed with `dev_sel[i]`. A device with `dev_sel[i]=0` sees no edges during a read.
- R7: With `auto_start=1`, a high-to-low transition of `busy_in` starts a read. `busy_in` passes through a two-flop synchroniser before the edge is detected.
- R8: With `auto_start=0`, the busy falling edge sets `irq_flag` and produces no clock edges. A one-cycle `read_req` in IDLE starts the read and clears `irq_flag`.
- R9: A busy falling edge that arrives during an active read is ignored. It starts no second read and raises no `irq_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_in | input | 1 | Converter busy line, asynchronous |
| auto_start | input | 1 | 1: busy falling edge starts the read; 0: it raises irq_flag |
| read_req | input | 1 | One-cycle host read request, accepted in IDLE |
| dev_sel | input | N_DEV | Active-high per-device clock enable |
| sdata_in | input | 1 | Serial data from the selected converter |
| sclk_out | output | N_DEV | Gated serial clock, one line per device |
| data_out | output | WORD_W | Last word read, MSB first order kept |
| data_valid | output | 1 | One-cycle strobe when data_out is updated |
| irq_flag | output | 1 | End of conversion pending in manual mode |

## Verification
The hardest case to reach from the ports is a busy falling edge that lands in the middle of a running burst. It must be dropped silently, and the only evidence is the absence of a second burst or flag. The bench starts an automatic read and waits about twenty cycles, well inside the sixteen-pulse burst. It then toggles `busy_in` high and low. After that it counts clock edges and valid strobes over a long quiet window. A reset issued mid-burst is handled the same way: the bench watches that no edge or strobe follows the reset.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_DONE
    } rd_state_e;
endpackage

// File: rtl/busy_edge_sync.sv
module busy_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic busy_async,
    output logic busy_fall
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= busy_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign busy_fall = prev_q & ~sync_q;
endmodule

// File: rtl/sclk_phase_timer.sv
module sclk_phase_timer #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = $clog2(DIV_HALF + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/msb_shift_reg.sv
module msb_shift_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[WIDTH-2:0], din};
        end
    end
endmodule

// File: rtl/adc_burst_reader.sv
module adc_burst_reader #(
    parameter int WORD_W   = 16,
    parameter int DIV_HALF = 2,
    parameter int N_DEV    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_in,
    input  logic              auto_start,
    input  logic              read_req,
    input  logic [N_DEV-1:0]  dev_sel,
    input  logic              sdata_in,
    output logic [N_DEV-1:0]  sclk_out,
    output logic [WORD_W-1:0] data_out,
    output logic              data_valid,
    output logic              irq_flag
);
    import adc_rd_pkg::*;

    localparam int BIT_W = $clog2(WORD_W + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    rd_state_e          state_q, state_d;
    logic               busy_fall;
    logic               tick;
    logic               run;
    logic               start;
    logic               shift_en;
    logic               sclk_int;
    logic [BIT_W-1:0]   bit_cnt_q;
    logic [WORD_W-1:0]  shift_q;
    logic [WORD_W-1:0]  result_q;
    logic               irq_q;

    busy_edge_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .busy_async(busy_in),
        .busy_fall (busy_fall)
    );

    sclk_phase_timer #(.DIV_HALF(DIV_HALF)) u_timer (
        .clk (clk),
        .rst (rst),
        .run (run),
        .tick(tick)
    );

    msb_shift_reg #(.WIDTH(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .shift_en(shift_en),
        .din     (sdata_in),
        .q       (shift_q)
    );

    assign start = (auto_start & busy_fall) | read_req;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LEAD;
            ST_LEAD: if (tick)  state_d = ST_HIGH;
            ST_HIGH: if (tick)  state_d = (bit_cnt_q == LAST_BIT) ? ST_DONE : ST_LOW;
            ST_LOW:  if (tick)  state_d = ST_HIGH;
            ST_DONE:            state_d = ST_IDLE;
            default:            state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        run        = 1'b0;
        sclk_int   = 1'b0;
        data_valid = 1'b0;
        shift_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LEAD: run = 1'b1;
            ST_HIGH: begin
                run      = 1'b1;
                sclk_int = 1'b1;
                shift_en = tick;
            end
            ST_LOW:  run = 1'b1;
            ST_DONE: data_valid = 1'b1;
            default: ;
        endcase
    end

    // bit counter, result and flag
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt_q <= '0;
            result_q  <= '0;
            irq_q     <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                bit_cnt_q <= '0;
            end else if (shift_en) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (shift_en && (bit_cnt_q == LAST_BIT)) begin
                result_q <= {shift_q[WORD_W-2:0], sdata_in};
            end
            if (state_q == ST_IDLE) begin
                if (start) begin
                    irq_q <= 1'b0;
                end else if (busy_fall && !auto_start) begin
                    irq_q <= 1'b1;
                end
            end
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_DEV; gi++) begin : g_gate
            assign sclk_out[gi] = sclk_int & dev_sel[gi];
        end
    endgenerate

    assign data_out = result_q;
    assign irq_flag = irq_q;
endmodule

// File: rtl/adc_burst_reader_chk.sv
module adc_burst_reader_chk #(
    parameter int DIV_HALF = 2,
    parameter int WORD_W   = 16
) (
    input logic clk,
    input logic rst,
    input logic sclk_int,
    input logic data_valid,
    input logic irq_flag,
    input logic auto_start
);
    localparam int RW = $clog2(WORD_W + 2);
    localparam int HW = $clog2(DIV_HALF + 2);

    logic          sclk_prev;
    logic [RW-1:0] rise_cnt;
    logic [HW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            rise_cnt  <= '0;
            hi_run    <= '0;
        end else begin
            sclk_prev <= sclk_int;
            if (data_valid) begin
                rise_cnt <= '0;
            end else if (sclk_int && !sclk_prev) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
            hi_run <= sclk_int ? hi_run + 1'b1 : '0;
        end
    end

    // R2
    pulse_count_chk: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (rise_cnt == RW'(WORD_W)));

    // R3
    high_width_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_int |-> (hi_run < HW'(DIV_HALF)));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> !data_valid);

    // R8
    irq_manual_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> !$past(auto_start));
endmodule

bind adc_burst_reader adc_burst_reader_chk #(.DIV_HALF(DIV_HALF), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sclk_int  (sclk_int),
    .data_valid(data_valid),
    .irq_flag  (irq_flag),
    .auto_start(auto_start)
);

// File: tb/adc_burst_reader_tb.sv
`timescale 1ns/1ps
module adc_burst_reader_tb;
    localparam int DIVH = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        busy_in = 1'b0;
    logic        auto_start = 1'b1;
    logic        read_req = 1'b0;
    logic [1:0]  dev_sel = 2'b01;
    logic        sdata_in;
    logic [1:0]  sclk_out;
    logic [15:0] data_out;
    logic        data_valid;
    logic        irq_flag;

    int checks = 0;
    int errors = 0;
    int e0 = 0, e1 = 0, idx0 = 0, idx1 = 0, vcnt = 0;
    logic [15:0] word_m = '0;
    logic s0 = 1'b0, s1 = 1'b0;

    // {dev_sel[1:0], auto_start, word[15:0]}
    localparam logic [18:0] VEC [6] = '{
        {2'b01, 1'b1, 16'hA5C3},
        {2'b01, 1'b1, 16'h8001},
        {2'b10, 1'b1, 16'hFFFF},
        {2'b01, 1'b0, 16'h0000},
        {2'b10, 1'b0, 16'h1234},
        {2'b01, 1'b1, 16'h7FFE}
    };

    adc_burst_reader #(.WORD_W(16), .DIV_HALF(DIVH), .N_DEV(2)) u_dut (
        .clk(clk), .rst(rst), .busy_in(busy_in), .auto_start(auto_start),
        .read_req(read_req), .dev_sel(dev_sel), .sdata_in(sdata_in),
        .sclk_out(sclk_out), .data_out(data_out), .data_valid(data_valid),
        .irq_flag(irq_flag)
    );

    always #4 clk = ~clk;

    assign sdata_in = (dev_sel[0] & s0) | (dev_sel[1] & s1);

    // slave models: launch next bit on rising clock
    always @(posedge sclk_out[0]) begin
        e0 = e0 + 1;
        #1;
        if (idx0 < 16) s0 = word_m[15 - idx0];
        idx0 = idx0 + 1;
    end
    always @(posedge sclk_out[1]) begin
        e1 = e1 + 1;
        #1;
        if (idx1 < 16) s1 = word_m[15 - idx1];
        idx1 = idx1 + 1;
    end
    always @(negedge clk) if (data_valid) vcnt = vcnt + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic prep(input logic [15:0] w);
        word_m = w; idx0 = 0; idx1 = 0; e0 = 0; e1 = 0;
    endtask

    task automatic pulse_busy();
        busy_in = 1'b1; cycles(4); busy_in = 1'b0;
    endtask

    task automatic wait_valid(input logic [15:0] w);
        bit got = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (data_valid) begin got = 1; break; end
        end
        chk(got, "R5 valid seen", 32'(got), 1);
        chk(data_out == w, "R4 word", 32'(data_out), 32'(w));
        cycles(1);
        chk(!data_valid, "R5 one cycle", 32'(data_valid), 0);
        chk(data_out == w, "R5 hold", 32'(data_out), 32'(w));
    endtask

    task automatic do_read(input logic [1:0] sel, input logic au, input logic [15:0] w);
        prep(w);
        dev_sel = sel; auto_start = au;
        pulse_busy();
        if (!au) begin
            cycles(10);
            chk(irq_flag == 1'b1, "R8 flag set", 32'(irq_flag), 1);
            chk(e0 + e1 == 0, "R8 no clock", 32'(e0 + e1), 0);
            read_req = 1'b1; cycles(1); read_req = 1'b0;
            chk(irq_flag == 1'b0, "R8 flag cleared", 32'(irq_flag), 0);
            chk(sclk_out == 2'b00, "R3 lead low a", 32'(sclk_out), 0);
            cycles(1);
            chk(sclk_out == 2'b00, "R3 lead low b", 32'(sclk_out), 0);
            cycles(1);
            chk(sclk_out == sel, "R3 first rise", 32'(sclk_out), 32'(sel));
            cycles(1);
            chk(sclk_out == sel, "R3 high phase", 32'(sclk_out), 32'(sel));
            cycles(1);
            chk(sclk_out == 2'b00, "R3 fall", 32'(sclk_out), 0);
        end
        wait_valid(w);
        chk((sel[0] ? e0 : e1) == 16, "R2 edge count", 32'(sel[0] ? e0 : e1), 16);
        chk((sel[0] ? e1 : e0) == 0, "R6 deselected quiet", 32'(sel[0] ? e1 : e0), 0);
        chk(sclk_out == 2'b00, "R3 low between words", 32'(sclk_out), 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v0, ea;
        cycles(3);
        // R1 reset state
        chk(sclk_out == 2'b00, "R1 sclk", 32'(sclk_out), 0);
        chk(!data_valid, "R1 valid", 32'(data_valid), 0);
        chk(!irq_flag, "R1 irq", 32'(irq_flag), 0);
        rst = 1'b0;
        cycles(1);
        chk(sclk_out == 2'b00 && !data_valid && !irq_flag, "R1 after", 32'({sclk_out, data_valid, irq_flag}), 0);

        // R7 / R8 table of reads
        foreach (VEC[k]) begin
            do_read(VEC[k][18:17], VEC[k][16], VEC[k][15:0]);
            cycles(5);
        end

        // R9 busy edge during a read is ignored
        prep(16'h3C5A); dev_sel = 2'b01; auto_start = 1'b1;
        pulse_busy();
        cycles(20);
        pulse_busy();
        wait_valid(16'h3C5A);
        v0 = vcnt;
        cycles(120);
        chk(e0 == 16, "R9 no second burst", 32'(e0), 16);
        chk(vcnt == v0, "R9 no second valid", 32'(vcnt), 32'(v0));
        chk(!irq_flag, "R9 no flag", 32'(irq_flag), 0);

        // R9 in manual mode: edge mid-read raises no flag
        prep(16'h0F0F); auto_start = 1'b0;
        read_req = 1'b1; cycles(1); read_req = 1'b0;
        cycles(15);
        pulse_busy();
        wait_valid(16'h0F0F);
        cycles(10);
        chk(!irq_flag, "R9 manual no flag", 32'(irq_flag), 0);

        // R1 reset in the middle of a read
        prep(16'hBEEF); auto_start = 1'b1;
        pulse_busy();
        cycles(25);
        rst = 1'b1; cycles(1); rst = 1'b0;
        chk(sclk_out == 2'b00 && !data_valid, "R1 mid-read reset", 32'({sclk_out, data_valid}), 0);
        ea = e0; v0 = vcnt;
        cycles(150);
        chk(e0 == ea, "R1 no edges after reset", 32'(e0), 32'(ea));
        chk(vcnt == v0, "R1 no valid after reset", 32'(vcnt), 32'(v0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule